// File: doc/BRIEF.md
# Oversampling Asynchronous Receiver with Standby Wakeup

This block receives asynchronous NRZ characters on a single serial line. A sample enable pulses at sixteen times the baud rate. Every bit time is therefore split into sixteen receive-time phases, RT1 to RT16. The start of a character is judged from a short vote of early samples. Each later bit is the two-of-three vote of samples taken at its centre. The recovered character is 8 or 9 data bits wide. It is handed over in a holding register together with per-character status: framing error, noise, parity error and break. An overrun flag marks characters that were lost.

A standby mode lets the block ignore traffic meant for other listeners on a shared line. Once standby is requested, incoming characters are thrown away without raising any flag. The block returns to normal reception in one of two ways, chosen by a configuration bit. In address-mark mode it wakes on a character whose most significant bit is 1, and that character is kept. In idle-line mode it wakes after one full character time of a continuously high line.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, rxFull, overrun, noiseErr, frameErr, parityErr, breakDet and standby are all 0.
- R2: A falling edge (a 0 sample after a 1 sample) marks RT1 of a candidate start bit. The line is sampled again at RT3, RT5 and RT7. If two or more of these three samples are 1, the candidate is dropped, nothing is received, and the search needs a new 1-then-0 edge.
- R3: Data bits arrive LSB first. Each data bit takes the majority of its RT8, RT9 and RT10 samples. With cfgNineBit=0 there are 8 data bits: rxData holds them and rxBit9 is 0. With cfgNineBit=1 there are 9: rxData holds bits 7..0 and rxBit9 holds bit 8.
- R4: If the majority value of the stop bit is 0, frameErr is set with the character.
- R5: A character whose data bits are all 0 and whose stop bit is 0 sets breakDet, together with frameErr.
- R6: noiseErr is set with the character if the three samples of any data bit or of the stop bit disagree, or if the RT3/RT5/RT7 samples of an accepted start bit are not all equal. The majority value is still stored.
- R7: If a character completes while rxFull is 1 and readStrobe is not asserted, it is discarded. overrun is set, and rxData and the other flags keep the earlier character.
- R8: With cfgParEn=1, the last data bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is the parity bit. parityErr is set when the count of 1s over all data bits is odd and cfgParOdd=0, or even and cfgParOdd=1.
- R9: A readStrobe cycle clears rxFull, overrun and all error flags. If a character completes in the same cycle, that character is stored and overrun stays 0.
- R10: standbyReq sets standby. With cfgWakeAddr=1, a character whose MSB is 1 (bit 7 in 8-bit, bit 8 in 9-bit mode) clears standby and is stored as normal. A character with MSB 0 is discarded.
- R11: With cfgWakeAddr=0, standby clears on the sample enable that completes 16 x (data bits + 2) consecutive 1 samples while no character is in progress. This count starts from the standbyReq pulse. In 8-bit mode it is 160 samples.
- R12: While standby is 1, a discarded character changes neither rxFull nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rtTick | input | 1 | Sample enable at 16x the baud rate |
| rxd | input | 1 | Serial receive line |
| cfgNineBit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfgParEn | input | 1 | Enables parity checking on the last data bit |
| cfgParOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgWakeAddr | input | 1 | Wake source: 1 address mark, 0 idle line |
| standbyReq | input | 1 | Pulse that enters standby |
| readStrobe | input | 1 | Consumes the held character and clears the flags |
| rxData | output | 8 | Received data bits 7..0 |
| rxBit9 | output | 1 | Ninth received data bit |
| rxFull | output | 1 | A character is waiting to be read |
| overrun | output | 1 | A character was lost while the holder was full |
| noiseErr | output | 1 | Sample disagreement in the held character |
| frameErr | output | 1 | Stop bit was read as 0 |
| parityErr | output | 1 | Parity mismatch in the held character |
| breakDet | output | 1 | Held character was an all-zero break |
| standby | output | 1 | Receiver is in standby |

## Verification
Clean 8-bit and 9-bit characters show that data is assembled LSB first and that the ninth bit is routed correctly. A single inverted sample at RT9 of a data bit, and another at RT5 of the start bit, separate majority voting from plain single sampling, since the data must stay correct while noiseErr rises. A low pulse of only four phases, compared with a true start bit, exercises the start-bit vote. Back-to-back characters with no read in between, and standby runs with address-marked and unmarked characters and with a long idle line, exercise the overrun and wakeup paths. These standby checks sample one enable before and one enable after the 160-sample limit.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_VERIFY,
    ST_BITS
  } rxState_e;

  // strobes from the control to the datapath, valid for one clock
  typedef struct packed {
    logic       clrAcc;   // start edge seen: clear accumulators
    logic       vSample;  // store an early start-bit sample
    logic       vJudge;   // last start-bit sample: decide
    logic       bSample;  // store a bit-centre sample
    logic       bLatch;   // last bit-centre sample: vote
    logic       isStop;   // current bit is the stop bit
    logic [3:0] idx;      // bit position, 1 = first data bit
  } rxStrobe_t;

endpackage

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
  import rxw_pkg::*;
#(
  parameter int RT_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rtTick,
  input  logic      rxd,
  input  logic      nineBit,
  input  logic      startBad,
  output rxStrobe_t stb,
  output logic      hunting
);

  localparam int CNT_W = $clog2(RT_PER_BIT);
  localparam int MID   = RT_PER_BIT / 2;
  localparam logic [CNT_W-1:0] PH_V1   = CNT_W'(MID - 6);  // RT3
  localparam logic [CNT_W-1:0] PH_V2   = CNT_W'(MID - 4);  // RT5
  localparam logic [CNT_W-1:0] PH_V3   = CNT_W'(MID - 2);  // RT7
  localparam logic [CNT_W-1:0] PH_B1   = CNT_W'(MID - 1);  // RT8
  localparam logic [CNT_W-1:0] PH_B2   = CNT_W'(MID);      // RT9
  localparam logic [CNT_W-1:0] PH_B3   = CNT_W'(MID + 1);  // RT10
  localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(RT_PER_BIT - 1);

  rxState_e         state;
  logic [CNT_W-1:0] rtCnt;
  logic [3:0]       bitIdx;
  logic             seenOne;
  logic [3:0]       stopIdx;

  assign stopIdx = nineBit ? 4'd10 : 4'd9;
  assign hunting = (state == ST_HUNT);

  always_comb begin
    stb         = '0;
    stb.idx     = bitIdx;
    stb.isStop  = (bitIdx == stopIdx);
    stb.clrAcc  = rtTick && hunting && !rxd && seenOne;
    if (rtTick && state == ST_VERIFY) begin
      stb.vSample = (rtCnt == PH_V1) || (rtCnt == PH_V2);
      stb.vJudge  = (rtCnt == PH_V3);
    end
    if (rtTick && state == ST_BITS) begin
      stb.bSample = (rtCnt == PH_B1) || (rtCnt == PH_B2);
      stb.bLatch  = (rtCnt == PH_B3);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      rtCnt   <= '0;
      bitIdx  <= '0;
      seenOne <= 1'b0;
    end else if (rtTick) begin
      unique case (state)
        ST_HUNT: begin
          if (rxd) begin
            seenOne <= 1'b1;
          end else if (seenOne) begin
            state   <= ST_VERIFY;
            rtCnt   <= CNT_W'(1);
            bitIdx  <= '0;
            seenOne <= 1'b0;
          end
        end
        ST_VERIFY: begin
          rtCnt <= rtCnt + 1'b1;
          if (rtCnt == PH_V3 && startBad) begin
            state   <= ST_HUNT;
            seenOne <= rxd;
          end else if (rtCnt == PH_LAST) begin
            state  <= ST_BITS;
            bitIdx <= 4'd1;
          end
        end
        ST_BITS: begin
          rtCnt <= rtCnt + 1'b1;
          if (rtCnt == PH_B3 && bitIdx == stopIdx) begin
            state   <= ST_HUNT;
            seenOne <= rxd;
          end else if (rtCnt == PH_LAST) begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/rxw_dpath.sv
module rxw_dpath
  import rxw_pkg::*;
#(
  parameter int RT_PER_BIT = 16,
  parameter int MAX_DBITS  = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rtTick,
  input  logic       rxd,
  input  logic       nineBit,
  input  logic       parEn,
  input  logic       parOdd,
  input  logic       wakeAddr,
  input  logic       standbyReq,
  input  logic       readStrobe,
  input  rxStrobe_t  stb,
  input  logic       hunting,
  output logic       startBad,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       rxFull,
  output logic       overrun,
  output logic       noiseErr,
  output logic       frameErr,
  output logic       parityErr,
  output logic       breakDet,
  output logic       standby
);

  localparam int IDLE_MAX = (MAX_DBITS + 2) * RT_PER_BIT;
  localparam int IW       = $clog2(IDLE_MAX + 1);

  logic [1:0]           smp;
  logic [MAX_DBITS-1:0] shReg;
  logic                 noiseAcc;
  logic [IW-1:0]        idleCnt;
  logic [IW-1:0]        idleLimit;

  logic vote, sampNoise, charDone, addrMark, parBad, isBreak;
  logic idleHit, accept, heldFull;

  // two-of-three vote over two stored samples and the live line
  assign vote      = (smp[1] & smp[0]) | (smp[1] & rxd) | (smp[0] & rxd);
  assign sampNoise = !((smp[1] == smp[0]) && (smp[0] == rxd));
  assign startBad  = vote;

  assign charDone  = stb.bLatch && stb.isStop;
  assign addrMark  = nineBit ? shReg[8] : shReg[7];
  assign parBad    = parEn && ((^shReg) != parOdd);
  assign isBreak   = (shReg == '0) && !vote;

  assign idleLimit = nineBit ? IW'(11 * RT_PER_BIT) : IW'(10 * RT_PER_BIT);
  assign idleHit   = rtTick && hunting && rxd && (idleCnt == idleLimit - 1'b1);

  assign accept    = charDone && (!standby || (wakeAddr && addrMark));
  assign heldFull  = rxFull && !readStrobe;

  // sample history and character assembly
  always_ff @(posedge clk) begin
    if (!rstN) begin
      smp      <= '0;
      shReg    <= '0;
      noiseAcc <= 1'b0;
    end else begin
      if (stb.vSample || stb.bSample) smp <= {smp[0], rxd};
      if (stb.clrAcc) begin
        shReg    <= '0;
        noiseAcc <= 1'b0;
      end
      if (stb.vJudge && !startBad) noiseAcc <= noiseAcc | sampNoise;
      if (stb.bLatch && !stb.isStop) begin
        noiseAcc <= noiseAcc | sampNoise;
        for (int i = 0; i < MAX_DBITS; i++) begin
          if (stb.idx == 4'(i + 1)) shReg[i] <= vote;
        end
      end
    end
  end

  // idle-line counter and standby state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
      standby <= 1'b0;
    end else begin
      if (standbyReq) begin
        idleCnt <= '0;
      end else if (rtTick) begin
        if (hunting && rxd) begin
          if (idleCnt != idleLimit) idleCnt <= idleCnt + 1'b1;
        end else begin
          idleCnt <= '0;
        end
      end
      if (standbyReq) begin
        standby <= 1'b1;
      end else if ((charDone && wakeAddr && addrMark) || (idleHit && !wakeAddr)) begin
        standby <= 1'b0;
      end
    end
  end

  // holding register and per-character status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      rxBit9    <= 1'b0;
      rxFull    <= 1'b0;
      overrun   <= 1'b0;
      noiseErr  <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
      breakDet  <= 1'b0;
    end else begin
      if (readStrobe) begin
        rxFull    <= 1'b0;
        overrun   <= 1'b0;
        noiseErr  <= 1'b0;
        frameErr  <= 1'b0;
        parityErr <= 1'b0;
        breakDet  <= 1'b0;
      end
      if (accept) begin
        if (heldFull) begin
          overrun <= 1'b1;
        end else begin
          rxData    <= shReg[7:0];
          rxBit9    <= nineBit & shReg[8];
          rxFull    <= 1'b1;
          noiseErr  <= noiseAcc | sampNoise;
          frameErr  <= !vote;
          parityErr <= parBad;
          breakDet  <= isBreak;
        end
      end
    end
  end

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import rxw_pkg::*;
#(
  parameter int RT_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rtTick,
  input  logic       rxd,
  input  logic       cfgNineBit,
  input  logic       cfgParEn,
  input  logic       cfgParOdd,
  input  logic       cfgWakeAddr,
  input  logic       standbyReq,
  input  logic       readStrobe,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       rxFull,
  output logic       overrun,
  output logic       noiseErr,
  output logic       frameErr,
  output logic       parityErr,
  output logic       breakDet,
  output logic       standby
);

  rxStrobe_t stb;
  logic      hunting;
  logic      startBad;

  rxw_ctrl #(.RT_PER_BIT(RT_PER_BIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rtTick   (rtTick),
    .rxd      (rxd),
    .nineBit  (cfgNineBit),
    .startBad (startBad),
    .stb      (stb),
    .hunting  (hunting)
  );

  rxw_dpath #(.RT_PER_BIT(RT_PER_BIT), .MAX_DBITS(9)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .rtTick     (rtTick),
    .rxd        (rxd),
    .nineBit    (cfgNineBit),
    .parEn      (cfgParEn),
    .parOdd     (cfgParOdd),
    .wakeAddr   (cfgWakeAddr),
    .standbyReq (standbyReq),
    .readStrobe (readStrobe),
    .stb        (stb),
    .hunting    (hunting),
    .startBad   (startBad),
    .rxData     (rxData),
    .rxBit9     (rxBit9),
    .rxFull     (rxFull),
    .overrun    (overrun),
    .noiseErr   (noiseErr),
    .frameErr   (frameErr),
    .parityErr  (parityErr),
    .breakDet   (breakDet),
    .standby    (standby)
  );

endmodule

// File: rtl/rxw_check.sv
module rxw_check (
  input logic       clk,
  input logic       rstN,
  input logic       rtTick,
  input logic       readStrobe,
  input logic [7:0] rxData,
  input logic       rxFull,
  input logic       overrun,
  input logic       noiseErr,
  input logic       frameErr,
  input logic       parityErr,
  input logic       breakDet,
  input logic       standby
);

  // R9: a read leaves no overrun behind
  p_read_clears_ovr_r9: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |=> !overrun);

  // R5: a break is always also a framing error
  p_break_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    breakDet |-> frameErr);

  // R7: overrun only exists beside a held character
  p_ovr_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> rxFull);

  // R4, R6, R8: status flags describe a held character
  p_flags_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (noiseErr || frameErr || parityErr) |-> rxFull);

  // R12: held data is frozen while standby persists
  p_standby_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (standby && $past(standby)) |-> $stable(rxData));

  // R3: a character only lands on a sample enable
  p_load_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(rtTick));

endmodule

bind uart_wake_rx rxw_check u_rxw_check (
  .clk        (clk),
  .rstN       (rstN),
  .rtTick     (rtTick),
  .readStrobe (readStrobe),
  .rxData     (rxData),
  .rxFull     (rxFull),
  .overrun    (overrun),
  .noiseErr   (noiseErr),
  .frameErr   (frameErr),
  .parityErr  (parityErr),
  .breakDet   (breakDet),
  .standby    (standby)
);

// File: tb/tb_uart_wake_rx.sv
`timescale 1ns/1ps
module tb_uart_wake_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rtTick = 1'b0;
  logic       rxd = 1'b1;
  logic       cfgNineBit = 1'b0;
  logic       cfgParEn = 1'b0;
  logic       cfgParOdd = 1'b0;
  logic       cfgWakeAddr = 1'b0;
  logic       standbyReq = 1'b0;
  logic       readStrobe = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9, rxFull, overrun, noiseErr, frameErr, parityErr, breakDet, standby;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_wake_rx dut (
    .clk(clk), .rstN(rstN), .rtTick(rtTick), .rxd(rxd),
    .cfgNineBit(cfgNineBit), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgWakeAddr(cfgWakeAddr), .standbyReq(standbyReq), .readStrobe(readStrobe),
    .rxData(rxData), .rxBit9(rxBit9), .rxFull(rxFull), .overrun(overrun),
    .noiseErr(noiseErr), .frameErr(frameErr), .parityErr(parityErr),
    .breakDet(breakDet), .standby(standby)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one sample enable, four clocks apart
  task automatic tickOnce(input logic v);
    @(negedge clk);
    rxd = v;
    rtTick = 1'b1;
    @(negedge clk);
    rtTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) tickOnce(1'b1);
  endtask

  // start, nb data bits LSB first, stop; one sample inverted at (gBit, gPh)
  task automatic sendFrame(input logic [8:0] d, input int nb, input logic stopV,
                           input int gBit, input int gPh);
    for (int b = 0; b < nb + 2; b++) begin
      for (int p = 1; p <= 16; p++) begin
        logic v;
        if (b == 0) v = 1'b0;
        else if (b == nb + 1) v = stopV;
        else v = d[b-1];
        if (b == gBit && p == gPh) v = ~v;
        tickOnce(v);
      end
    end
    idleTicks(32);
  endtask

  task automatic readChar();
    @(negedge clk);
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "rxFull", rxFull, 0);
    chk("R1", "flags", {overrun, noiseErr, frameErr, parityErr, breakDet}, 0);
    chk("R1", "standby", standby, 0);
  endtask

  task automatic testEightBit();
    sendFrame(9'h0A5, 8, 1'b1, -1, 0);
    chk("R3", "8-bit data", rxData, 8'hA5);
    chk("R3", "8-bit full", rxFull, 1);
    chk("R3", "8-bit bit9", rxBit9, 0);
    chk("R4", "clean frame", frameErr, 0);
    chk("R6", "clean noise", noiseErr, 0);
    readChar();
    chk("R9", "read clears full", rxFull, 0);
  endtask

  task automatic testNineBit();
    cfgNineBit = 1'b1;
    sendFrame(9'h13C, 9, 1'b1, -1, 0);
    chk("R3", "9-bit data", rxData, 8'h3C);
    chk("R3", "9-bit bit9", rxBit9, 1);
    chk("R4", "9-bit frame", frameErr, 0);
    readChar();
    cfgNineBit = 1'b0;
  endtask

  task automatic testFalseStart();
    // low for RT1..RT4 only: RT5 and RT7 read 1
    for (int i = 0; i < 4; i++) tickOnce(1'b0);
    idleTicks(200);
    chk("R2", "false start ignored", rxFull, 0);
    // RT5 inverted on a real start: accepted, flagged noisy
    sendFrame(9'h05A, 8, 1'b1, 0, 5);
    chk("R2", "noisy start data", rxData, 8'h5A);
    chk("R6", "start noise flag", noiseErr, 1);
    readChar();
  endtask

  task automatic testDataNoise();
    sendFrame(9'h0C3, 8, 1'b1, 4, 9);
    chk("R3", "majority data", rxData, 8'hC3);
    chk("R6", "data noise flag", noiseErr, 1);
    readChar();
    chk("R9", "read clears noise", noiseErr, 0);
  endtask

  task automatic testFraming();
    sendFrame(9'h081, 8, 1'b0, -1, 0);
    chk("R4", "bad stop", frameErr, 1);
    chk("R5", "not a break", breakDet, 0);
    readChar();
    sendFrame(9'h000, 8, 1'b0, -1, 0);
    chk("R5", "break flag", breakDet, 1);
    chk("R5", "break framing", frameErr, 1);
    readChar();
    chk("R9", "read clears break", breakDet, 0);
  endtask

  task automatic testOverrun();
    sendFrame(9'h011, 8, 1'b1, -1, 0);
    sendFrame(9'h022, 8, 1'b1, -1, 0);
    chk("R7", "overrun flag", overrun, 1);
    chk("R7", "first kept", rxData, 8'h11);
    readChar();
    chk("R9", "read clears ovr", overrun, 0);
  endtask

  task automatic testParity();
    cfgParEn = 1'b1;
    cfgParOdd = 1'b0;
    sendFrame(9'h003, 8, 1'b1, -1, 0);
    chk("R8", "even ok", parityErr, 0);
    readChar();
    sendFrame(9'h007, 8, 1'b1, -1, 0);
    chk("R8", "even bad", parityErr, 1);
    readChar();
    cfgParOdd = 1'b1;
    sendFrame(9'h007, 8, 1'b1, -1, 0);
    chk("R8", "odd ok", parityErr, 0);
    readChar();
    cfgParEn = 1'b0;
    cfgParOdd = 1'b0;
  endtask

  task automatic testAddrWake();
    cfgWakeAddr = 1'b1;
    @(negedge clk) standbyReq = 1'b1;
    @(negedge clk) standbyReq = 1'b0;
    chk("R10", "standby set", standby, 1);
    sendFrame(9'h012, 8, 1'b0, -1, 0);
    chk("R12", "unmarked dropped", rxFull, 0);
    chk("R12", "no flag in standby", frameErr, 0);
    chk("R10", "still standby", standby, 1);
    sendFrame(9'h085, 8, 1'b1, -1, 0);
    chk("R10", "woken", standby, 0);
    chk("R10", "mark kept", rxData, 8'h85);
    readChar();
  endtask

  task automatic testIdleWake();
    cfgWakeAddr = 1'b0;
    @(negedge clk) standbyReq = 1'b1;
    @(negedge clk) standbyReq = 1'b0;
    sendFrame(9'h0F0, 8, 1'b1, -1, 0);
    chk("R12", "idle-mode drop", rxFull, 0);
    chk("R11", "standby held", standby, 1);
    @(negedge clk) standbyReq = 1'b1;
    @(negedge clk) standbyReq = 1'b0;
    idleTicks(159);
    chk("R11", "before limit", standby, 1);
    idleTicks(1);
    chk("R11", "at limit", standby, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    idleTicks(20);
    testEightBit();
    testNineBit();
    testFalseStart();
    testDataNoise();
    testFraming();
    testOverrun();
    testParity();
    testAddrWake();
    testIdleWake();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule